// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter with Bit-Serial Distributed Arithmetic

The block takes a stream of signed samples, each marked by a valid strobe, and delivers one filtered signed sample for every two it accepts. The filter is an 11-tap half-band FIR. The incoming stream is split by parity before any arithmetic. Samples in the second slot of each pair feed the symmetric outer taps. Samples in the first slot feed only the centre tap, which weighs 0.5. Only the outputs that are kept are ever computed.

The symmetric taps use no multipliers. The three pairs of samples that share a coefficient are first added together. The sums are then walked one bit per clock, least significant bit first. Each step adds an entry from an eight-entry table of coefficient sums, scaled by two to the power of the bit index. The last step, on the sign bit, subtracts its entry instead. The centre sample is weighted by 0.5 with a shift and added at the end. The coefficients are fixed parameters. An input that arrives too soon to start a new computation is refused and reported.

Top module: `hb_da_decim`

## Requirements
- R1: Exactly one output is produced for every two accepted inputs once the filter has filled, and no output is ever produced from a single input.
- R2: Each output equals y = sum over k of h[k]*x[n-k], with n being the index of the second sample of the pair (odd accepted index, counted from 0 after reset). The coefficients are h = {C0,0,C2,0,C4,2^(FB-1),C4,0,C2,0,C0}, with FB fractional bits (defaults C0=12, C2=-66, C4=310, FB=10). The result is delivered at full precision as a signed OW-bit integer.
- R3: A second-slot input that arrives fewer than DW+1 clocks after the previous accepted second-slot input is refused. `overflow` is then high for the single cycle after it, and the refused sample does not enter the filter state. An input that arrives exactly DW+1 clocks after is accepted, and `overflow` stays low.
- R4: `out_valid` pulses for one cycle, DW+1 clock edges after the edge that accepts the second sample of the pair.
- R5: During and after reset, `out_valid` and `overflow` are low, and all delay lines are zero.
- R6: No output appears until 12 inputs have been accepted. The first output corresponds to n = 11.
- R7: A first-slot input is always accepted, even while the previous output is still being computed.
- R8: Inputs at full-scale positive and full-scale negative values give exact results, because the sign bit of each pre-added sum is weighted negatively.
- R9: The centre tap contributes exactly x[n-5]*2^(FB-1). An isolated impulse therefore reproduces the coefficient values at the decimated output.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle |
| out_data | output | OW | Signed full-precision output (FB fractional bits) |
| overflow | output | 1 | One-cycle pulse after a refused input |

## Verification
Isolated impulses, placed in both pair slots, expose each coefficient and the centre shift separately. This tells a wrong tap ordering or a wrong phase apart from a wrong table entry. Full-scale alternating and constant negative inputs separate a correct sign-bit subtraction from an unsigned walk. Paced pairs at exactly DW+1 clocks, and one clock short of that, distinguish the acceptance boundary from an off-by-one. Random values with random gaps then mix accepted and refused samples, and every output is compared against a direct convolution that keeps every second result.

// File: rtl/hb_da_decim.sv
`timescale 1ns/1ps
module hb_da_decim #(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int FB = 10,
  parameter int signed C0 = 12,
  parameter int signed C2 = -66,
  parameter int signed C4 = 310,
  parameter int OW = DW + CW + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic                 overflow
);
  localparam int SW   = DW + 1;
  localparam int LW   = CW + 2;
  localparam int CNTW = $clog2(SW);
  localparam int OLEN = 5;
  localparam int ELEN = 3;

  function automatic logic signed [LW-1:0] coef_sum(input logic [2:0] a);
    int v;
    v = 0;
    if (a[0]) v += C0;
    if (a[1]) v += C2;
    if (a[2]) v += C4;
    return LW'(v);
  endfunction

  logic signed [DW-1:0] odd_line [OLEN];
  logic signed [DW-1:0] even_line [ELEN];
  logic signed [SW-1:0] sr0, sr1, sr2;
  logic signed [DW-1:0] ctr;
  logic signed [OW-1:0] acc, term, nxt, cterm;
  logic [CNTW-1:0]      cnt;
  logic [2:0]           fill;
  logic                 phase, busy, emit;

  wire last      = busy && (cnt == CNTW'(SW - 1));
  wire take_odd  = in_valid && phase && (!busy || last);
  wire take_even = in_valid && !phase;
  wire reject    = in_valid && phase && busy && !last;

  wire signed [SW-1:0] pre0 = {in_data[DW-1], in_data} + {odd_line[4][DW-1], odd_line[4]};
  wire signed [SW-1:0] pre1 = {odd_line[0][DW-1], odd_line[0]} + {odd_line[3][DW-1], odd_line[3]};
  wire signed [SW-1:0] pre2 = {odd_line[1][DW-1], odd_line[1]} + {odd_line[2][DW-1], odd_line[2]};

  always_comb begin
    term  = OW'(coef_sum({sr2[cnt], sr1[cnt], sr0[cnt]})) <<< cnt;
    nxt   = last ? acc - term : acc + term;
    cterm = OW'(ctr) <<< (FB - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < OLEN; i++) odd_line[i] <= '0;
      for (int i = 0; i < ELEN; i++) even_line[i] <= '0;
      sr0 <= '0; sr1 <= '0; sr2 <= '0;
      ctr <= '0; acc <= '0; cnt <= '0; fill <= '0;
      phase <= 1'b0; busy <= 1'b0; emit <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; overflow <= 1'b0;
    end else begin
      overflow  <= reject;
      out_valid <= 1'b0;
      if (busy) begin
        if (last) begin
          busy      <= 1'b0;
          out_valid <= emit;
          if (emit) out_data <= nxt + cterm;
        end else begin
          acc <= nxt;
          cnt <= cnt + 1'b1;
        end
      end
      if (take_even) begin
        even_line[0] <= in_data;
        for (int i = 1; i < ELEN; i++) even_line[i] <= even_line[i-1];
        phase <= 1'b1;
      end
      if (take_odd) begin
        odd_line[0] <= in_data;
        for (int i = 1; i < OLEN; i++) odd_line[i] <= odd_line[i-1];
        sr0 <= pre0; sr1 <= pre1; sr2 <= pre2;
        ctr   <= even_line[ELEN-1];
        emit  <= (fill == 3'(OLEN));
        if (fill != 3'(OLEN)) fill <= fill + 1'b1;
        acc   <= '0;
        cnt   <= '0;
        busy  <= 1'b1;
        phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hb_da_decim_chk.sv
`timescale 1ns/1ps
module hb_da_decim_chk #(
  parameter int DW = 12,
  parameter int OW = DW + 15
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data,
  input logic          overflow
);
  localparam int SW = DW + 1;
  int gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= SW;
    else if (out_valid) gap <= 1;
    else if (gap < SW) gap <= gap + 1;
  end

  p_reset_quiet_r5: assert property (@(posedge clk) rst |=> (!out_valid && !overflow));
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  p_output_rate_r1: assert property (@(posedge clk) disable iff (rst) out_valid |-> gap >= SW);
  p_overflow_cause_r3: assert property (@(posedge clk) disable iff (rst) overflow |-> $past(in_valid));
  p_data_hold_r2: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_data));
endmodule

bind hb_da_decim hb_da_decim_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
);

// File: tb/test_hb_da_decim.sv
`timescale 1ns/1ps
module test_hb_da_decim;
  localparam int DW = 12, CW = 12, FB = 10;
  localparam int C0 = 12, C2 = -66, C4 = 310;
  localparam int OW = DW + CW + 3;
  localparam int SW = DW + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, out_valid, overflow;
  logic signed [DW-1:0] in_data;
  logic signed [OW-1:0] out_data;

  hb_da_decim #(.DW(DW), .CW(CW), .FB(FB), .C0(C0), .C2(C2), .C4(C4), .OW(OW)) i_hb_da_decim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow));

  int n_chk = 0, n_fail = 0, nacc = 0, nout = 0, qh = 0, qt = 0;
  string tag = "R5 reset";
  int hist [8192];
  longint exp_val [2048];
  longint exp_cyc [2048];
  longint cyc = 0, last_odd = -1000;
  int h [11];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic longint model(input int n);
    longint s = 0;
    for (int k = 0; k < 11; k++)
      if (n - k >= 0) s += longint'(h[k]) * longint'(hist[n-k]);
    return s;
  endfunction

  task automatic send(input int v, input int idle);
    longint acc_c;
    bit odd, ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v[DW-1:0];
    acc_c = cyc + 1;
    odd = (nacc % 2) == 1;
    ok  = !odd || (acc_c - last_odd >= SW);
    if (ok) begin
      hist[nacc] = v;
      if (odd) begin
        last_odd = acc_c;
        if (nacc >= 11) begin
          exp_val[qt] = model(nacc);
          exp_cyc[qt] = acc_c + SW;
          qt++;
        end
      end
      nacc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(overflow == !ok, "R3 overflow flag", longint'(overflow), longint'(!ok));
    repeat (idle) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      nout++;
      if (qh == qt) check(1'b0, "R6 R1 unexpected output", longint'(out_data), 0);
      else begin
        check(longint'(out_data) == exp_val[qh], "R2 output value", longint'(out_data), exp_val[qh]);
        check(cyc == exp_cyc[qh], "R4 output cycle", cyc, exp_cyc[qh]);
        qh++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tag = "watchdog";
    check(1'b0, "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    h = '{C0, 0, C2, 0, C4, 1 << (FB - 1), C4, 0, C2, 0, C0};
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid in reset", longint'(out_valid), 0);
    check(overflow == 1'b0, "R5 overflow in reset", longint'(overflow), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid after reset", longint'(out_valid), 0);

    tag = "R6 fill";
    for (int i = 0; i < 11; i++) send(int'($urandom_range(4095)) - 2048, 12);
    repeat (20) @(negedge clk);
    check(nout == 0, "R6 no output before 12 inputs", nout, 0);
    send(int'($urandom_range(4095)) - 2048, 20);
    check(nout == 1, "R6 first output after 12th input", nout, 1);

    tag = "R9 impulse";
    for (int i = 0; i < 12; i++) send(0, 12);
    send(1000, 12);
    for (int i = 0; i < 13; i++) send(0, 12);
    send(-700, 12);
    for (int i = 0; i < 12; i++) send(0, 12);

    tag = "R8 extremes";
    for (int i = 0; i < 20; i++) send((i % 2) ? -2048 : 2047, 12);
    for (int i = 0; i < 20; i++) send(-2048, 12);
    for (int i = 0; i < 20; i++) send(2047, 12);

    tag = "R7 R3 boundary pacing";
    if (nacc % 2 == 0) send(0, 12);
    for (int i = 0; i < 30; i++) begin
      send(int'($urandom_range(4095)) - 2048, 0);
      send(int'($urandom_range(4095)) - 2048, 9);
    end

    tag = "R3 early input";
    repeat (20) @(negedge clk);
    if (nacc % 2 == 0) send(0, 12);
    for (int i = 0; i < 20; i++) begin
      send(int'($urandom_range(4095)) - 2048, 0);
      send(int'($urandom_range(4095)) - 2048, 8);
      send(int'($urandom_range(4095)) - 2048, 0);
    end

    tag = "R2 random";
    for (int i = 0; i < 600; i++)
      send(int'($urandom_range(4095)) - 2048, int'($urandom_range(14)));

    repeat (40) @(negedge clk);
    tag = "R1 totals";
    check(qh == qt, "R1 all expected outputs delivered", qh, qt);
    check(nout == (nacc - 10) / 2, "R1 one output per accepted pair", nout, (nacc - 10) / 2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule